// File: doc/BRIEF.md
# AC97-Style Serial Frame Link

This block carries fixed-format audio frames between a controller and one codec over a serial link. Every frame is 256 bit periods long: a 16-bit tag slot followed by twelve 20-bit data slots. On the transmit side it takes a parallel tag and twelve parallel slot words and shifts them out on one data line. It also drives a frame sync that marks the tag slot. On the receive side it shifts one data line into a frame-wide register and presents the finished frame as a parallel tag and slots, with a one-cycle strobe.

The block runs on a single system clock. An external clock generator supplies two single-cycle strobes that mark the rising and falling edges of the serial bit clock. The two strobes never fall in the same cycle.

The mode enable forces a fixed set of line conventions: the sync marks the whole tag slot, and it is active high. Transmit bits change on the rising-edge strobe and receive bits are sampled on the falling-edge strobe. These conventions apply whatever values are programmed on the general-purpose configuration inputs. The programmed values take effect again only once the mode is switched off. While the mode is off, the link is idle.

Top module: `ac97_link`

## Requirements
- R1: A frame is the 256-bit vector {tag, slots}. The 16-bit tag is in bits 255:240. Data slot n (n = 1..12) is in bits 20*(13-n)-1 down to 20*(12-n). On the ports, slot 1 is therefore tx_slots[239:220] and slot 12 is tx_slots[19:0]; rx_slots uses the same layout.
- R2: Frame bits are sent and received most significant first. Bit 255 is in the first bit period of a frame and bit 0 is in the last.
- R3: While enabled, sdo changes only in the cycle after a cycle with bclk_rise high. sdi is sampled only in cycles with bclk_fall high.
- R4: While enabled, fs_out is high (active high) for the 16 bit periods of the tag slot. It is low for the remaining 240 bit periods.
- R5: After bit period 255, the next rising strobe starts a new frame at bit period 0 with no gap.
- R6: tx_tag and tx_slots are sampled only when a frame starts. A change made during a frame appears in the next frame.
- R7: rx_valid is a one-cycle pulse in the cycle after the 256th bit of a frame is sampled. rx_tag and rx_slots then present that frame and hold it until the next complete frame.
- R8: While link_en is high, cfg_fs_active_low, cfg_fs_one_bit and cfg_edge_swap have no effect on sdo, fs_out, rx_valid or the received data.
- R9: While link_en is low, sdo is low, any partial frame is dropped, and fs_out sits at its programmed inactive level: high when cfg_fs_active_low is 1, low otherwise. After re-enabling, the first rising strobe starts a frame at bit period 0.
- R10: While rst_n is low at a clock edge, sdo, rx_valid, rx_tag and rx_slots clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_en | input | 1 | Mode enable; forces the fixed line conventions |
| bclk_rise | input | 1 | Single-cycle strobe marking a bit-clock rising edge |
| bclk_fall | input | 1 | Single-cycle strobe marking a bit-clock falling edge |
| cfg_fs_active_low | input | 1 | Programmed sync polarity (1 = active low) |
| cfg_fs_one_bit | input | 1 | Programmed sync length (1 = one bit period) |
| cfg_edge_swap | input | 1 | Programmed edges (1 = transmit on fall, receive on rise) |
| tx_tag | input | 16 | Tag slot to transmit |
| tx_slots | input | 240 | Twelve 20-bit slots to transmit, slot 1 in the top bits |
| sdo | output | 1 | Serial transmit data |
| fs_out | output | 1 | Frame sync |
| sdi | input | 1 | Serial receive data |
| rx_tag | output | 16 | Received tag slot |
| rx_slots | output | 240 | Received twelve slots, slot 1 in the top bits |
| rx_valid | output | 1 | One-cycle strobe when a received frame is complete |

## Verification
The transmit side is driven with a distinctive tag and pseudo-random slots, and the receive line carries a separate random stream. Any swap of slot order, bit order or transmit/receive coupling therefore shows up as a mismatch. An all-zero tag with an alternating receive pattern separates a stuck or inverted line from correct shifting. Slot words are rewritten in the middle of a frame to tell sampling at the boundary apart from sampling live. The programmed configuration inputs are set to their non-default values while the mode is enabled, and the link is then disabled mid-frame. Together these two steps show the override while the mode is on and the return of the programmed sync level once it is off.

// File: rtl/ac97_link_pkg.sv
// Package: types shared by the frame link modules.
// Assumes: the programmed line settings arrive as static configuration bits.
package ac97_link_pkg;

    // Programmed general-purpose line settings that the mode enable overrides.
    typedef struct packed {
        logic fs_active_low;  // sync polarity, 1 = active low
        logic fs_one_bit;     // sync length, 1 = single bit period
        logic edge_swap;      // 1 = transmit on fall, receive on rise
    } line_cfg_t;

endpackage

// File: rtl/ac97_cfg_override.sv
// Module: resolves the line settings that are in force.
// While the mode enable is high, all fields are forced to their fixed values
// (zero). Otherwise the programmed values pass through. The programmed values
// are never changed here.
module ac97_cfg_override
    import ac97_link_pkg::*;
(
    input  logic      en,
    input  line_cfg_t prog,
    output line_cfg_t eff
);

    // Select the forced conventions while the mode is enabled.
    always_comb begin
        if (en) begin
            eff = '0;
        end else begin
            eff = prog;
        end
    end

endmodule

// File: rtl/ac97_tx_framer.sv
// Module: transmit framer. It owns the frame bit counter, loads the parallel
// frame at each frame start, shifts it out MSB first and drives frame sync.
// Assumes: the rise and fall strobes never coincide. The link is idle while
// en is low.
module ac97_tx_framer
    import ac97_link_pkg::*;
#(
    parameter int TAG_W   = 16,
    parameter int FRAME_W = 256,
    localparam int CNT_W  = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               bclk_rise,
    input  logic               bclk_fall,
    input  line_cfg_t          eff,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               sdo,
    output logic               fs_pin,
    output logic               running,
    output logic [CNT_W-1:0]   bit_idx
);

    logic [FRAME_W-1:0] shreg;
    logic               fs_act;
    logic               tx_stb;
    logic               last_bit;

    // Pick the launching strobe from the settings in force.
    always_comb begin
        tx_stb   = eff.edge_swap ? bclk_fall : bclk_rise;
        last_bit = (bit_idx == CNT_W'(FRAME_W - 1));
    end

    // Bit counter, shifter and sync generation.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            running <= 1'b0;
            bit_idx <= '0;
            shreg   <= '0;
            sdo     <= 1'b0;
            fs_act  <= 1'b0;
        end else if (tx_stb) begin
            if (!running || last_bit) begin
                running <= 1'b1;
                bit_idx <= '0;
                sdo     <= frame_in[FRAME_W-1];
                shreg   <= frame_in << 1;
                fs_act  <= 1'b1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
                sdo     <= shreg[FRAME_W-1];
                shreg   <= shreg << 1;
                fs_act  <= eff.fs_one_bit ? 1'b0 : (bit_idx < CNT_W'(TAG_W - 1));
            end
        end
    end

    // Apply the polarity in force to the sync pin.
    always_comb fs_pin = fs_act ^ eff.fs_active_low;

    // Sync falls after the last tag bit.
    assert_fs_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en && running && tx_stb && !eff.fs_one_bit && bit_idx == CNT_W'(TAG_W - 1)
        |=> !fs_act);

    // Counter wraps into a new frame with sync raised.
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en && running && tx_stb && last_bit |=> running && bit_idx == '0 && fs_act);

    // Data holds between launching strobes.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en && running && !tx_stb |=> $stable(sdo));

    // Disabled link is quiet.
    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !running && !sdo && !fs_act);

    // Sync is active high while the mode is on.
    assert_fs_polarity_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en && !fs_act |-> !fs_pin);

endmodule

// File: rtl/ac97_rx_deframer.sv
// Module: receive deframer. It shifts sdi in MSB first, aligned to the
// framer's bit counter, and captures the whole frame with a one-cycle strobe
// after the final bit. Assumes: bit_idx and running come from the framer.
module ac97_rx_deframer #(
    parameter int FRAME_W = 256,
    localparam int CNT_W  = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               rx_stb,
    input  logic               running,
    input  logic [CNT_W-1:0]   bit_idx,
    input  logic               sdi,
    output logic [FRAME_W-1:0] rx_frame,
    output logic               rx_valid
);

    logic [FRAME_W-1:0] sh;
    logic               take;

    // A sample is taken only inside a running frame.
    always_comb take = en && running && rx_stb;

    // Shift in received bits and latch a completed frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            rx_frame <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (take) begin
                sh <= {sh[FRAME_W-2:0], sdi};
                if (bit_idx == CNT_W'(FRAME_W - 1)) begin
                    rx_frame <= {sh[FRAME_W-2:0], sdi};
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    // Strobe lasts one cycle.
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // Strobe follows an enabled sample.
    assert_valid_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(en && rx_stb && running));

    // Captured frame holds between strobes.
    assert_frame_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid && !take |=> $stable(rx_frame));

endmodule

// File: rtl/ac97_link.sv
// Module: top of the serial frame link. It packs the tag and slots into one
// frame vector, resolves the line settings, and connects the framer and the
// deframer. Assumes: strobes come from an external bit-clock generator.
module ac97_link
    import ac97_link_pkg::*;
#(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12,
    localparam int SLOT_BITS = SLOT_W * NUM_SLOTS,
    localparam int FRAME_W   = TAG_W + SLOT_BITS,
    localparam int CNT_W     = $clog2(FRAME_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 link_en,
    input  logic                 bclk_rise,
    input  logic                 bclk_fall,
    input  logic                 cfg_fs_active_low,
    input  logic                 cfg_fs_one_bit,
    input  logic                 cfg_edge_swap,
    input  logic [TAG_W-1:0]     tx_tag,
    input  logic [SLOT_BITS-1:0] tx_slots,
    output logic                 sdo,
    output logic                 fs_out,
    input  logic                 sdi,
    output logic [TAG_W-1:0]     rx_tag,
    output logic [SLOT_BITS-1:0] rx_slots,
    output logic                 rx_valid
);

    line_cfg_t          prog_cfg;
    line_cfg_t          eff_cfg;
    logic [FRAME_W-1:0] tx_frame;
    logic [FRAME_W-1:0] rx_frame;
    logic               running;
    logic [CNT_W-1:0]   bit_idx;
    logic               rx_stb;

    // Gather the programmed fields and the outgoing frame.
    always_comb begin
        prog_cfg.fs_active_low = cfg_fs_active_low;
        prog_cfg.fs_one_bit    = cfg_fs_one_bit;
        prog_cfg.edge_swap     = cfg_edge_swap;
        tx_frame               = {tx_tag, tx_slots};
        rx_stb                 = eff_cfg.edge_swap ? bclk_rise : bclk_fall;
    end

    ac97_cfg_override u_override (
        .en   (link_en),
        .prog (prog_cfg),
        .eff  (eff_cfg)
    );

    ac97_tx_framer #(
        .TAG_W   (TAG_W),
        .FRAME_W (FRAME_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (link_en),
        .bclk_rise (bclk_rise),
        .bclk_fall (bclk_fall),
        .eff       (eff_cfg),
        .frame_in  (tx_frame),
        .sdo       (sdo),
        .fs_pin    (fs_out),
        .running   (running),
        .bit_idx   (bit_idx)
    );

    ac97_rx_deframer #(
        .FRAME_W (FRAME_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (link_en),
        .rx_stb   (rx_stb),
        .running  (running),
        .bit_idx  (bit_idx),
        .sdi      (sdi),
        .rx_frame (rx_frame),
        .rx_valid (rx_valid)
    );

    // Split the captured frame into tag and slots.
    always_comb begin
        rx_tag   = rx_frame[FRAME_W-1 -: TAG_W];
        rx_slots = rx_frame[SLOT_BITS-1:0];
    end

    // Disabled link shows the programmed inactive sync level.
    assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> (!link_en -> fs_out == cfg_fs_active_low));

endmodule

// File: tb/ac97_link_bench.sv
`timescale 1ns/1ps
module ac97_link_bench;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         link_en;
    logic         bclk_rise;
    logic         bclk_fall;
    logic         cfg_fs_active_low;
    logic         cfg_fs_one_bit;
    logic         cfg_edge_swap;
    logic [15:0]  tx_tag;
    logic [239:0] tx_slots;
    logic         sdo;
    logic         fs_out;
    logic         sdi;
    logic [15:0]  rx_tag;
    logic [239:0] rx_slots;
    logic         rx_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference state
    bit           m_run;
    int           m_cnt;
    logic [255:0] m_frame;
    logic         m_sdo;
    logic         m_fsact;
    logic [255:0] m_rxbits;
    logic [255:0] m_rxframe;
    logic         m_valid;
    logic         prev_rise;
    logic         prev_sdo;
    int           prev_cnt;
    logic [255:0] rx_src;
    int           ph;
    string        cur_req;

    always #2.5 clk = ~clk;

    ac97_link u_ac97_link (
        .clk               (clk),
        .rst_n             (rst_n),
        .link_en           (link_en),
        .bclk_rise         (bclk_rise),
        .bclk_fall         (bclk_fall),
        .cfg_fs_active_low (cfg_fs_active_low),
        .cfg_fs_one_bit    (cfg_fs_one_bit),
        .cfg_edge_swap     (cfg_edge_swap),
        .tx_tag            (tx_tag),
        .tx_slots          (tx_slots),
        .sdo               (sdo),
        .fs_out            (fs_out),
        .sdi               (sdi),
        .rx_tag            (rx_tag),
        .rx_slots          (rx_slots),
        .rx_valid          (rx_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference, advanced at each rising clock edge.
    task automatic model_step();
        prev_rise = bclk_rise && link_en;
        prev_cnt  = m_cnt;
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_sdo = 0; m_fsact = 0;
            m_rxframe = '0; m_valid = 0;
        end else begin
            m_valid = 0;
            if (!link_en) begin
                m_run = 0; m_cnt = 0; m_sdo = 0; m_fsact = 0;
            end else begin
                if (bclk_fall && m_run) begin
                    m_rxbits[255 - m_cnt] = sdi;
                    if (m_cnt == 255) begin
                        m_rxframe = m_rxbits;
                        m_valid   = 1;
                    end
                end
                if (bclk_rise) begin
                    if (!m_run || m_cnt == 255) begin
                        m_run   = 1;
                        m_cnt   = 0;
                        m_frame = {tx_tag, tx_slots};
                    end else begin
                        m_cnt++;
                    end
                    m_sdo   = m_frame[255 - m_cnt];
                    m_fsact = (m_cnt < 16);
                end
            end
        end
    endtask

    task automatic compare();
        logic exp_fs;
        exp_fs = link_en ? m_fsact : cfg_fs_active_low;
        chk(sdo === m_sdo, {cur_req, " R2 sdo"}, 256'(sdo), 256'(m_sdo));
        chk(fs_out === exp_fs, {cur_req, " R4 fs_out"}, 256'(fs_out), 256'(exp_fs));
        chk(rx_valid === m_valid, "R7 rx_valid", 256'(rx_valid), 256'(m_valid));
        if (m_valid)
            chk({rx_tag, rx_slots} === m_rxframe, "R1 received frame",
                {rx_tag, rx_slots}, m_rxframe);
        if (link_en && m_run && !prev_rise)
            chk(sdo === prev_sdo, "R3 sdo held between strobes", 256'(sdo), 256'(prev_sdo));
        if (link_en && prev_rise && m_cnt == 0 && prev_cnt == 255)
            chk(fs_out === 1'b1, "R5 wrap restarts frame", 256'(fs_out), 256'(1));
        prev_sdo = sdo;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    // Drive strobes: rise in phase 0, fall in phase 2.
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            bclk_rise = (ph == 0);
            bclk_fall = (ph == 2);
            sdi       = m_run ? rx_src[255 - m_cnt] : 1'b0;
            ph        = (ph + 1) % 4;
            tick();
        end
    endtask

    function automatic logic [239:0] rand_slots();
        logic [239:0] v;
        for (int k = 0; k < 8; k++) v[k*30 +: 30] = 30'($urandom);
        return v;
    endfunction

    function automatic logic [255:0] rand_frame();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        rst_n = 0; link_en = 0; bclk_rise = 0; bclk_fall = 0; sdi = 0;
        cfg_fs_active_low = 0; cfg_fs_one_bit = 0; cfg_edge_swap = 0;
        tx_tag = '0; tx_slots = '0; rx_src = '0; ph = 0; cur_req = "R10";
        m_rxbits = '0; m_frame = '0; prev_sdo = 0; prev_cnt = 0; prev_rise = 0;
        m_run = 0; m_cnt = 0; m_sdo = 0; m_fsact = 0; m_rxframe = '0; m_valid = 0;
        repeat (3) tick();
        // R10: reset state
        chk(sdo === 1'b0, "R10 sdo after reset", 256'(sdo), 256'(0));
        chk(rx_valid === 1'b0, "R10 rx_valid after reset", 256'(rx_valid), 256'(0));
        chk({rx_tag, rx_slots} === '0, "R10 rx data after reset", {rx_tag, rx_slots}, '0);
        rst_n = 1;

        // Distinct tag, random slots, independent random receive stream.
        cur_req  = "R1";
        tx_tag   = 16'h9C35;
        tx_slots = rand_slots();
        rx_src   = rand_frame();
        link_en  = 1;
        run(1024 + 500);
        // R6: rewrite slots mid-frame; the model samples at the boundary only.
        cur_req  = "R6";
        tx_slots = rand_slots();
        tx_tag   = 16'h0F1E;
        rx_src   = rand_frame();
        run(1400);

        // R8: programmed fields set to non-default values while enabled.
        cur_req           = "R8";
        cfg_fs_active_low = 1;
        cfg_fs_one_bit    = 1;
        cfg_edge_swap     = 1;
        run(1100);

        // R9: disable mid-frame; programmed polarity returns.
        cur_req = "R9";
        link_en = 0;
        run(8);
        chk(fs_out === 1'b1, "R9 fs idle level active-low", 256'(fs_out), 256'(1));
        chk(sdo === 1'b0, "R9 sdo idle low", 256'(sdo), 256'(0));
        cfg_fs_active_low = 0;
        run(4);
        chk(fs_out === 1'b0, "R9 fs idle level active-high", 256'(fs_out), 256'(0));
        cfg_fs_active_low = 1;

        // Re-enable: zero tag, alternating receive pattern.
        cur_req  = "R9";
        tx_tag   = '0;
        tx_slots = {12{20'hA5C3F}};
        rx_src   = {64{4'hA}};
        link_en  = 1;
        run(2100);
        chk({rx_tag, rx_slots} === {64{4'hA}}, "R7 alternating frame held",
            {rx_tag, rx_slots}, {64{4'hA}});

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule